// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block is the byte-wide programming port of an eight-line programmable interrupt controller. It sits in front of a separate request/service core. Software writes bytes to one of two register addresses. The block sorts each byte into one of two kinds: a step of a multi-byte setup sequence, or a runtime command. It keeps the resulting configuration: edge or level triggering, single or cascaded operation, the vector base, the cascade map or the slave identifier, and automatic end-of-interrupt.

Runtime commands on address 0 do three things. They raise one-cycle end-of-interrupt strobes for the core, each carrying a line number and a specific/nonspecific flag. They choose whether address-0 reads return the pending or the in-service set. They record the rotation and special-mask settings, which have no other effect. A setup sequencer decides what a write to address 1 means: either new mask data or the next setup byte. The path the sequencer takes depends on fields captured from the first setup byte. Reads are combinational and return the core's pending or in-service vector, or the mask held here.

Top module: `irq_cmd_decoder`

## Requirements
- R1: After reset the mask is 0, automatic end-of-interrupt is off, no end-of-interrupt strobe is active, and an address-0 read returns `core_irr`.
- R2: A write to address 0 with bit 4 set starts setup on the following edge. It clears the mask, sets edge mode to bit 3, sets cascade mode to the inverse of bit 1, and records bit 0 as "fourth byte expected".
- R3: When that first setup byte has bit 0 clear, automatic end-of-interrupt is cleared. The next address-1 write is then taken as the second setup byte and leaves the mask unchanged.
- R4: The second setup byte sets the vector base to the byte with bits 2:0 forced to 0. In cascade mode the sequencer then waits for a third byte. Otherwise the cascade map is cleared and the sequencer returns to idle.
- R5: The third setup byte is stored whole as the cascade map when `master_sel` is 1. When `master_sel` is 0, only bits 2:0 are kept and the upper bits are 0. The sequencer then waits for a fourth byte if one was requested, and otherwise goes idle.
- R6: The fourth setup byte sets automatic end-of-interrupt from bit 1 and always returns the sequencer to idle.
- R7: An address-1 write while idle loads the mask. An address-1 read returns the mask.
- R8: An address-0 write with bits 4:3 = 00 and bits 7:5 = 3 makes `eoi_valid` high for exactly the cycle after the write edge, with `eoi_line` equal to bits 2:0 and `eoi_specific` = 1.
- R9: Command code 1 (bits 7:5) gives a nonspecific strobe (`eoi_specific` = 0) on the highest set bit of `core_isr` at the write. No strobe is given when `core_isr` is 0.
- R10: Command codes 0, 2 and 4 to 7 give no strobe and leave the mask and the setup state unchanged.
- R11: Code 4 sets `rot_aeoi` and code 0 clears it. An address-0 write with bits 4:3 = 01 and bit 7 set loads `spec_mask_mode` from bit 6.
- R12: An address-0 write with bits 4:3 = 01 and bit 1 set makes later address-0 reads return `core_irr` if bit 0 is 1, or `core_isr` if bit 0 is 0. With bit 1 clear, the selection is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_sel | input | 1 | Static role select: 1 master, 0 slave |
| bus_we | input | 1 | Write strobe, one byte per high cycle |
| bus_addr | input | 1 | Register address (0 or 1) |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte for `bus_addr` |
| core_irr | input | 8 | Pending-request vector from the core |
| core_isr | input | 8 | In-service vector from the core |
| mask_out | output | 8 | Interrupt mask register |
| edge_mode | output | 1 | 1 edge-triggered, 0 level |
| cascade_mode | output | 1 | 1 cascaded, 0 single |
| vec_base | output | 8 | Vector base, low 3 bits zero |
| casc_map | output | 8 | Slave map (master) or slave ID (slave) |
| auto_eoi | output | 1 | Automatic end-of-interrupt enabled |
| rot_aeoi | output | 1 | Recorded rotation-in-auto-EOI setting |
| spec_mask_mode | output | 1 | Recorded special-mask setting |
| eoi_valid | output | 1 | End-of-interrupt strobe |
| eoi_line | output | 3 | Line the strobe applies to |
| eoi_specific | output | 1 | 1 specific, 0 nonspecific |

## Verification
A sequencer left in the wrong state shows up on the next address-1 write. Either the mask changes when it should hold, or a configuration output changes when the mask should have. The bench therefore reads the mask back after every setup byte and after the first data write that follows. A wrong end-of-interrupt decode appears within one cycle as a missing, extra or misdirected strobe. A wrong read-select state appears on the very next address-0 read, because the pending and in-service vectors are driven with different values.

// File: rtl/picd_pkg.sv
package picd_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_W2   = 2'd1,
    SEQ_W3   = 2'd2,
    SEQ_W4   = 2'd3
  } seq_t;

  typedef enum logic [2:0] {
    CMD_NONE   = 3'd0,
    CMD_INIT1  = 3'd1,
    CMD_EOI    = 3'd2,
    CMD_RDMASK = 3'd3,
    CMD_DATA   = 3'd4
  } cmd_t;

  // bit positions inside a written byte that neighbours decode
  localparam int B_INIT     = 4;
  localparam int B_KIND_LO  = 3;
  localparam int B_EDGE     = 3;
  localparam int B_SINGLE   = 1;
  localparam int B_NEED4    = 0;
  localparam int B_AEOI     = 1;
  localparam int B_SEL_EN   = 1;
  localparam int B_SEL_IRR  = 0;
  localparam int B_SMM_EN   = 7;
  localparam int B_SMM_VAL  = 6;
  localparam int CODE_LO    = 5;
  localparam int CODE_W     = 3;

  localparam logic [CODE_W-1:0] CODE_ROT_CLR = 3'd0;
  localparam logic [CODE_W-1:0] CODE_NS_EOI  = 3'd1;
  localparam logic [CODE_W-1:0] CODE_SP_EOI  = 3'd3;
  localparam logic [CODE_W-1:0] CODE_ROT_SET = 3'd4;

endpackage

// File: rtl/picd_decode.sv
module picd_decode
  import picd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          we,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output cmd_t          cmd
);

  always_comb begin
    cmd = CMD_NONE;
    if (we) begin
      if (addr) begin
        cmd = CMD_DATA;
      end else if (wdata[B_INIT]) begin
        cmd = CMD_INIT1;
      end else if (wdata[B_KIND_LO]) begin
        cmd = CMD_RDMASK;
      end else begin
        cmd = CMD_EOI;
      end
    end
  end

endmodule

// File: rtl/picd_init_seq.sv
module picd_init_seq
  import picd_pkg::*;
#(
  parameter int NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 master_sel,
  input  cmd_t                 cmd,
  input  logic [NUM_LINES-1:0] wdata,
  output logic [NUM_LINES-1:0] mask_q,
  output logic                 edge_q,
  output logic                 cascade_q,
  output logic [NUM_LINES-1:0] vec_q,
  output logic [NUM_LINES-1:0] map_q,
  output logic                 aeoi_q,
  output seq_t                 state_q
);

  localparam int LINE_W = $clog2(NUM_LINES);
  localparam logic [NUM_LINES-1:0] LOW_MASK = NUM_LINES'((1 << LINE_W) - 1);

  seq_t                 state_d;
  logic                 need4_q, need4_d;
  logic [NUM_LINES-1:0] mask_d, vec_d, map_d;
  logic                 edge_d, cascade_d, aeoi_d;
  logic                 upd_en;

  assign upd_en = (cmd == CMD_INIT1) || (cmd == CMD_DATA);

  always_comb begin
    state_d   = state_q;
    need4_d   = need4_q;
    mask_d    = mask_q;
    vec_d     = vec_q;
    map_d     = map_q;
    edge_d    = edge_q;
    cascade_d = cascade_q;
    aeoi_d    = aeoi_q;
    if (cmd == CMD_INIT1) begin
      mask_d    = '0;
      edge_d    = wdata[B_EDGE];
      cascade_d = ~wdata[B_SINGLE];
      need4_d   = wdata[B_NEED4];
      if (!wdata[B_NEED4]) aeoi_d = 1'b0;
      state_d   = SEQ_W2;
    end else if (cmd == CMD_DATA) begin
      unique case (state_q)
        SEQ_IDLE: mask_d = wdata;
        SEQ_W2: begin
          vec_d = wdata & ~LOW_MASK;
          if (cascade_q) begin
            state_d = SEQ_W3;
          end else begin
            map_d   = '0;
            state_d = SEQ_IDLE;
          end
        end
        SEQ_W3: begin
          map_d   = master_sel ? wdata : (wdata & LOW_MASK);
          state_d = need4_q ? SEQ_W4 : SEQ_IDLE;
        end
        SEQ_W4: begin
          aeoi_d  = wdata[B_AEOI];
          state_d = SEQ_IDLE;
        end
        default: state_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SEQ_IDLE;
      need4_q   <= 1'b0;
      mask_q    <= '0;
      vec_q     <= '0;
      map_q     <= '0;
      edge_q    <= 1'b0;
      cascade_q <= 1'b0;
      aeoi_q    <= 1'b0;
    end else if (upd_en) begin
      state_q   <= state_d;
      need4_q   <= need4_d;
      mask_q    <= mask_d;
      vec_q     <= vec_d;
      map_q     <= map_d;
      edge_q    <= edge_d;
      cascade_q <= cascade_d;
      aeoi_q    <= aeoi_d;
    end
  end

endmodule

// File: rtl/picd_ocw.sv
module picd_ocw
  import picd_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int LINE_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  cmd_t                 cmd,
  input  logic [NUM_LINES-1:0] wdata,
  input  logic [NUM_LINES-1:0] core_isr,
  output logic                 rd_irr_q,
  output logic                 rot_q,
  output logic                 smm_q,
  output logic                 eoi_vld_q,
  output logic [LINE_W-1:0]    eoi_line_q,
  output logic                 eoi_spec_q
);

  logic [CODE_W-1:0] code;
  logic [LINE_W-1:0] top_line;
  logic              isr_any;
  logic              rd_irr_d, rot_d, smm_d;
  logic              eoi_vld_d, eoi_spec_d;
  logic [LINE_W-1:0] eoi_line_d;
  logic              cfg_en;

  assign code    = wdata[CODE_LO +: CODE_W];
  assign isr_any = |core_isr;
  assign cfg_en  = (cmd == CMD_EOI) || (cmd == CMD_RDMASK);

  // highest set in-service bit
  always_comb begin
    top_line = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (core_isr[i]) top_line = LINE_W'(i);
    end
  end

  always_comb begin
    rd_irr_d   = rd_irr_q;
    rot_d      = rot_q;
    smm_d      = smm_q;
    eoi_vld_d  = 1'b0;
    eoi_spec_d = 1'b0;
    eoi_line_d = '0;
    if (cmd == CMD_EOI) begin
      unique case (code)
        CODE_SP_EOI: begin
          eoi_vld_d  = 1'b1;
          eoi_spec_d = 1'b1;
          eoi_line_d = wdata[LINE_W-1:0];
        end
        CODE_NS_EOI: begin
          eoi_vld_d  = isr_any;
          eoi_line_d = top_line;
        end
        CODE_ROT_SET: rot_d = 1'b1;
        CODE_ROT_CLR: rot_d = 1'b0;
        default: ;
      endcase
    end else if (cmd == CMD_RDMASK) begin
      if (wdata[B_SEL_EN]) rd_irr_d = wdata[B_SEL_IRR];
      if (wdata[B_SMM_EN]) smm_d    = wdata[B_SMM_VAL];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_irr_q <= 1'b1;
      rot_q    <= 1'b0;
      smm_q    <= 1'b0;
    end else if (cfg_en) begin
      rd_irr_q <= rd_irr_d;
      rot_q    <= rot_d;
      smm_q    <= smm_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoi_vld_q  <= 1'b0;
      eoi_spec_q <= 1'b0;
      eoi_line_q <= '0;
    end else begin
      eoi_vld_q  <= eoi_vld_d;
      eoi_spec_q <= eoi_spec_d;
      eoi_line_q <= eoi_line_d;
    end
  end

endmodule

// File: rtl/irq_cmd_decoder.sv
module irq_cmd_decoder
  import picd_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int LINE_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 master_sel,
  input  logic                 bus_we,
  input  logic                 bus_addr,
  input  logic [NUM_LINES-1:0] bus_wdata,
  output logic [NUM_LINES-1:0] bus_rdata,
  input  logic [NUM_LINES-1:0] core_irr,
  input  logic [NUM_LINES-1:0] core_isr,
  output logic [NUM_LINES-1:0] mask_out,
  output logic                 edge_mode,
  output logic                 cascade_mode,
  output logic [NUM_LINES-1:0] vec_base,
  output logic [NUM_LINES-1:0] casc_map,
  output logic                 auto_eoi,
  output logic                 rot_aeoi,
  output logic                 spec_mask_mode,
  output logic                 eoi_valid,
  output logic [LINE_W-1:0]    eoi_line,
  output logic                 eoi_specific
);

  cmd_t cmd;
  seq_t seq_state;
  logic rd_irr;

  picd_decode #(.DW(NUM_LINES)) u_dec (
    .we    (bus_we),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .cmd   (cmd)
  );

  picd_init_seq #(.NUM_LINES(NUM_LINES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .master_sel (master_sel),
    .cmd        (cmd),
    .wdata      (bus_wdata),
    .mask_q     (mask_out),
    .edge_q     (edge_mode),
    .cascade_q  (cascade_mode),
    .vec_q      (vec_base),
    .map_q      (casc_map),
    .aeoi_q     (auto_eoi),
    .state_q    (seq_state)
  );

  picd_ocw #(.NUM_LINES(NUM_LINES)) u_ocw (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd        (cmd),
    .wdata      (bus_wdata),
    .core_isr   (core_isr),
    .rd_irr_q   (rd_irr),
    .rot_q      (rot_aeoi),
    .smm_q      (spec_mask_mode),
    .eoi_vld_q  (eoi_valid),
    .eoi_line_q (eoi_line),
    .eoi_spec_q (eoi_specific)
  );

  always_comb begin
    if (bus_addr)    bus_rdata = mask_out;
    else if (rd_irr) bus_rdata = core_irr;
    else             bus_rdata = core_isr;
  end

endmodule

// File: rtl/picd_checker.sv
module picd_checker #(
  parameter int NUM_LINES = 8,
  localparam int LINE_W = $clog2(NUM_LINES)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 master_sel,
  input logic                 we,
  input logic                 addr,
  input logic [NUM_LINES-1:0] wdata,
  input logic [NUM_LINES-1:0] mask,
  input logic [NUM_LINES-1:0] vec,
  input logic [NUM_LINES-1:0] map,
  input logic                 eoi_valid,
  input logic [LINE_W-1:0]    eoi_line,
  input logic                 eoi_specific,
  input logic [1:0]           seq_state
);

  p_init_clears_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !addr && wdata[4]) |=> (mask == '0));

  p_vec_low_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vec[LINE_W-1:0] == '0);

  p_slave_id_narrow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr && seq_state == 2'd2 && !master_sel) |=> (map[NUM_LINES-1:LINE_W] == '0));

  p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!we || (addr && seq_state != 2'd0)) |=> $stable(mask));

  p_eoi_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid |-> $past(we && !addr && wdata[4:3] == 2'b00));

  p_specific_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid && eoi_specific) |-> (eoi_line == $past(wdata[LINE_W-1:0])));

  p_other_codes_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !addr && wdata[4:3] == 2'b00 && wdata[7:5] != 3'd1 && wdata[7:5] != 3'd3)
      |=> !eoi_valid);

endmodule

bind irq_cmd_decoder picd_checker #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .master_sel   (master_sel),
  .we           (bus_we),
  .addr         (bus_addr),
  .wdata        (bus_wdata),
  .mask         (mask_out),
  .vec          (vec_base),
  .map          (casc_map),
  .eoi_valid    (eoi_valid),
  .eoi_line     (eoi_line),
  .eoi_specific (eoi_specific),
  .seq_state    (u_seq.state_q)
);

// File: tb/irq_cmd_decoder_test.sv
`timescale 1ns/1ps
module irq_cmd_decoder_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       master_sel;
  logic       bus_we;
  logic       bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [7:0] core_irr;
  logic [7:0] core_isr;
  logic [7:0] mask_out;
  logic       edge_mode, cascade_mode;
  logic [7:0] vec_base, casc_map;
  logic       auto_eoi, rot_aeoi, spec_mask_mode;
  logic       eoi_valid;
  logic [2:0] eoi_line;
  logic       eoi_specific;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  irq_cmd_decoder uut (
    .clk(clk), .rst_n(rst_n), .master_sel(master_sel),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .core_irr(core_irr), .core_isr(core_isr), .mask_out(mask_out),
    .edge_mode(edge_mode), .cascade_mode(cascade_mode), .vec_base(vec_base),
    .casc_map(casc_map), .auto_eoi(auto_eoi), .rot_aeoi(rot_aeoi),
    .spec_mask_mode(spec_mask_mode), .eoi_valid(eoi_valid), .eoi_line(eoi_line),
    .eoi_specific(eoi_specific)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one write; returns at the negedge after the write edge
  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] r;
    rd(1'b0, r);
    check("R1 addr0 read is irr", r, 8'hA5);
    check("R1 mask", mask_out, 8'h00);
    check("R1 auto_eoi", auto_eoi, 1'b0);
    check("R1 eoi_valid", eoi_valid, 1'b0);
  endtask

  task automatic t_mask;
    logic [7:0] r;
    wr(1'b1, 8'h5A);
    check("R7 mask load", mask_out, 8'h5A);
    rd(1'b1, r);
    check("R7 addr1 read", r, 8'h5A);
  endtask

  task automatic t_cascade_master;
    master_sel = 1'b1;
    wr(1'b0, 8'h11);
    check("R2 mask cleared", mask_out, 8'h00);
    check("R2 edge from bit3", edge_mode, 1'b0);
    check("R2 cascade", cascade_mode, 1'b1);
    wr(1'b1, 8'h47);
    check("R4 vec base", vec_base, 8'h40);
    check("R4 mask held", mask_out, 8'h00);
    wr(1'b1, 8'hC3);
    check("R5 master map whole", casc_map, 8'hC3);
    wr(1'b1, 8'h03);
    check("R6 auto_eoi set", auto_eoi, 1'b1);
    check("R6 mask held", mask_out, 8'h00);
    wr(1'b1, 8'h66);
    check("R6 idle after word4", mask_out, 8'h66);
    check("R6 auto_eoi kept", auto_eoi, 1'b1);
  endtask

  task automatic t_single;
    wr(1'b0, 8'h1A);
    check("R2 mask cleared", mask_out, 8'h00);
    check("R2 edge set", edge_mode, 1'b1);
    check("R2 single", cascade_mode, 1'b0);
    check("R3 auto_eoi cleared", auto_eoi, 1'b0);
    wr(1'b1, 8'h9F);
    check("R3 mask held on word2", mask_out, 8'h00);
    check("R4 vec base low zero", vec_base, 8'h98);
    check("R4 map cleared in single", casc_map, 8'h00);
    wr(1'b1, 8'h33);
    check("R4 idle after word2", mask_out, 8'h33);
    check("R4 vec kept", vec_base, 8'h98);
  endtask

  task automatic t_slave;
    master_sel = 1'b0;
    wr(1'b0, 8'h11);
    wr(1'b1, 8'h20);
    wr(1'b1, 8'hFE);
    check("R5 slave id low bits", casc_map, 8'h06);
    wr(1'b1, 8'h00);
    check("R6 auto_eoi clear", auto_eoi, 1'b0);
    wr(1'b1, 8'h0F);
    check("R6 idle, mask load", mask_out, 8'h0F);
    wr(1'b0, 8'h10);
    wr(1'b1, 8'h28);
    check("R4 vec slave", vec_base, 8'h28);
    wr(1'b1, 8'h05);
    check("R5 slave id", casc_map, 8'h05);
    wr(1'b1, 8'h77);
    check("R5 idle without word4", mask_out, 8'h77);
    master_sel = 1'b1;
  endtask

  task automatic t_eoi;
    wr(1'b0, 8'h65);
    check("R8 strobe", eoi_valid, 1'b1);
    check("R8 line", eoi_line, 3'd5);
    check("R8 specific", eoi_specific, 1'b1);
    @(negedge clk);
    check("R8 strobe one cycle", eoi_valid, 1'b0);
    core_isr = 8'h3C;
    wr(1'b0, 8'h20);
    check("R9 strobe", eoi_valid, 1'b1);
    check("R9 highest isr", eoi_line, 3'd5);
    check("R9 nonspecific", eoi_specific, 1'b0);
    core_isr = 8'h00;
    wr(1'b0, 8'h20);
    check("R9 no strobe on empty isr", eoi_valid, 1'b0);
    core_isr = 8'h3C;
    wr(1'b0, 8'h40);
    check("R10 code2 silent", eoi_valid, 1'b0);
    wr(1'b0, 8'hE2);
    check("R10 code7 silent", eoi_valid, 1'b0);
    wr(1'b0, 8'hC4);
    check("R10 code6 silent", eoi_valid, 1'b0);
    check("R10 mask untouched", mask_out, 8'h77);
    wr(1'b1, 8'h12);
    check("R10 still idle", mask_out, 8'h12);
  endtask

  task automatic t_rot_smm;
    wr(1'b0, 8'h80);
    check("R11 rot set", rot_aeoi, 1'b1);
    check("R10 code4 silent", eoi_valid, 1'b0);
    wr(1'b0, 8'h00);
    check("R11 rot clear", rot_aeoi, 1'b0);
    wr(1'b0, 8'hC8);
    check("R11 smm set", spec_mask_mode, 1'b1);
    wr(1'b0, 8'h88);
    check("R11 smm clear", spec_mask_mode, 1'b0);
  endtask

  task automatic t_readsel;
    logic [7:0] r;
    wr(1'b0, 8'h0A);
    rd(1'b0, r);
    check("R12 select isr", r, 8'h3C);
    wr(1'b0, 8'h08);
    rd(1'b0, r);
    check("R12 unchanged without bit1", r, 8'h3C);
    wr(1'b0, 8'h0B);
    rd(1'b0, r);
    check("R12 select irr", r, 8'hA5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; master_sel = 1'b1; bus_we = 1'b0; bus_addr = 1'b0;
    bus_wdata = 8'h00; core_irr = 8'hA5; core_isr = 8'h3C;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask();
    t_cascade_master();
    t_single();
    t_slave();
    t_eoi();
    t_rot_smm();
    t_readsel();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule